// File: doc/BRIEF.md
# Equalization Convergence Iteration Tracker

This block oversees the fine-tuning phases of serial link equalization. Each lane reports a direction-change feedback code, and the block counts for every lane how many evaluation results in a row asked for no change. A lane is converged once that run reaches a programmed length. The phase is over when every lane has converged, when the iteration budget is used up, or when a fixed 24 ms timeout expires.

Software or the link state machine raises `phase_act_i` for the whole phase. While it is high, the block counts iterations: every preset-feedback event and every evaluate-request event adds one. The iteration cap can be masked, which leaves only convergence and the timeout to end the phase. `done_o` and a 2-bit reason code report the outcome and hold until the phase input drops. Dropping the phase input clears all state.

Top module: `eq_conv_tracker`

## Requirements
- R1: A lane's converged flag goes high in the cycle after its Nth consecutive valid feedback with all-zero code, where N is `conv_cnt_i`. Lanes whose valid bit is low keep their count.
- R2: A valid nonzero feedback code on a lane restarts that lane's run count at zero. If the lane was converged, its converged flag drops in the next cycle.
- R3: A programmed `conv_cnt_i` of 0 behaves as 1, so one all-zero feedback converges the lane.
- R4: `all_conv_o` is high exactly when every lane's converged flag is high.
- R5: Each cycle with `preset_fb_i` high adds one iteration, and each cycle with `eval_req_i` high adds one. When both are high in the same cycle, two iterations are added.
- R6: With the mask clear, `done_o` rises with reason 2'b10 (iteration limit) one cycle after the iteration count first reaches or exceeds `max_iter_i`.
- R7: With `iter_lim_dis_i` set, the iteration count never ends the phase, whatever `max_iter_i` holds.
- R8: `done_o` rises with reason 2'b11 (timeout) one cycle after `CYC_PER_MS*TIMEOUT_MS` cycles of an active phase have elapsed. This happens whether or not the mask is set.
- R9: `done_o` rises with reason 2'b01 (converged) one cycle after `all_conv_o` goes high. Converged has priority over the iteration limit, and the iteration limit has priority over the timeout.
- R10: Once `done_o` is high, it and its reason hold. Further feedback and events leave the lane flags unchanged.
- R11: A cycle with `phase_act_i` low clears the lane flags, `done_o` and the reason (2'b00), and restarts the iteration and timeout counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_act_i | input | 1 | Equalization fine-tuning phase in progress |
| fb_valid_i | input | NUM_LANES | Per-lane feedback strobe |
| fb_code_i | input | NUM_LANES*FB_W | Per-lane direction-change code, lane l at bits [l*FB_W +: FB_W]; all zeros means no change |
| preset_fb_i | input | 1 | Preset-feedback event, one iteration |
| eval_req_i | input | 1 | Evaluate-request event, one iteration |
| conv_cnt_i | input | CNT_W | Consecutive no-change results needed for convergence |
| max_iter_i | input | ITER_W | Iteration budget |
| iter_lim_dis_i | input | 1 | Masks the iteration budget |
| lane_conv_o | output | NUM_LANES | Per-lane converged flags |
| all_conv_o | output | 1 | Every lane converged |
| done_o | output | 1 | Phase finished |
| done_rsn_o | output | 2 | 01 converged, 10 iteration limit, 11 timeout, 00 running |

## Verification
Convergence and the iteration limit can become true in the same cycle. The bench provokes this by delivering the last all-zero feedback on every lane together with the evaluate request that brings the iteration count to the budget. It then expects `done_o` one cycle later with reason 01, not 10. A second pairing, in which the limit is reached with only one lane converged, confirms that the limit code is produced when convergence is absent, and that later feedback cannot move the lane flags.

// File: rtl/eq_conv_pkg.sv
`timescale 1ns/1ps
package eq_conv_pkg;
  typedef enum logic [1:0] {
    RSN_NONE  = 2'b00,
    RSN_CONV  = 2'b01,
    RSN_LIMIT = 2'b10,
    RSN_TMO   = 2'b11
  } done_rsn_e;
endpackage

// File: rtl/eq_lane_conv.sv
`timescale 1ns/1ps
module eq_lane_conv #(
  parameter int FB_W  = 6,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [FB_W-1:0]  code_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             conv_o
);
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] tgt;

  // zero target still needs one no-change result
  assign tgt = (target_i == '0) ? CNT_W'(1) : target_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (clr_i) begin
      run_q <= '0;
    end else if (en_i && valid_i) begin
      if (code_i != '0)      run_q <= '0;
      else if (run_q < tgt)  run_q <= run_q + CNT_W'(1);
    end
  end

  assign conv_o = (run_q >= tgt);
endmodule

// File: rtl/eq_iter_cnt.sv
`timescale 1ns/1ps
module eq_iter_cnt #(
  parameter int ITER_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              preset_fb_i,
  input  logic              eval_req_i,
  input  logic [ITER_W-1:0] max_iter_i,
  input  logic              mask_i,
  output logic              lim_hit_o
);
  localparam int SUM_W = ITER_W + 1;
  localparam logic [SUM_W-1:0] CAP = {1'b0, {ITER_W{1'b1}}};

  logic [ITER_W-1:0] cnt_q;
  logic [SUM_W-1:0]  sum;
  logic [1:0]        inc;

  assign inc = {1'b0, preset_fb_i} + {1'b0, eval_req_i};
  assign sum = {1'b0, cnt_q} + SUM_W'(inc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= (sum > CAP) ? {ITER_W{1'b1}} : sum[ITER_W-1:0];
  end

  assign lim_hit_o = !mask_i && (cnt_q >= max_iter_i);
endmodule

// File: rtl/eq_timeout.sv
`timescale 1ns/1ps
module eq_timeout #(
  parameter int CYC_PER_MS = 250,
  parameter int TIMEOUT_MS = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tmo_o
);
  localparam int PRE_W = $clog2(CYC_PER_MS + 1);
  localparam int MS_W  = $clog2(TIMEOUT_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_END   = MS_W'(TIMEOUT_MS);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (en_i && (ms_q != MS_END)) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        ms_q  <= ms_q + MS_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  assign tmo_o = (ms_q == MS_END);
endmodule

// File: rtl/eq_conv_tracker.sv
`timescale 1ns/1ps
module eq_conv_tracker
  import eq_conv_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int FB_W       = 6,
  parameter int CNT_W      = 3,
  parameter int ITER_W     = 8,
  parameter int CYC_PER_MS = 250,
  parameter int TIMEOUT_MS = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      phase_act_i,
  input  logic [NUM_LANES-1:0]      fb_valid_i,
  input  logic [NUM_LANES*FB_W-1:0] fb_code_i,
  input  logic                      preset_fb_i,
  input  logic                      eval_req_i,
  input  logic [CNT_W-1:0]          conv_cnt_i,
  input  logic [ITER_W-1:0]         max_iter_i,
  input  logic                      iter_lim_dis_i,
  output logic [NUM_LANES-1:0]      lane_conv_o,
  output logic                      all_conv_o,
  output logic                      done_o,
  output logic [1:0]                done_rsn_o
);
  logic       clr;
  logic       run_en;
  logic       lim_hit;
  logic       tmo_hit;
  logic       done_q;
  done_rsn_e  rsn_q;
  done_rsn_e  rsn_d;

  assign clr    = !phase_act_i;
  assign run_en = phase_act_i && !done_q;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    eq_lane_conv #(
      .FB_W  (FB_W),
      .CNT_W (CNT_W)
    ) i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr),
      .en_i     (run_en),
      .valid_i  (fb_valid_i[l]),
      .code_i   (fb_code_i[l*FB_W +: FB_W]),
      .target_i (conv_cnt_i),
      .conv_o   (lane_conv_o[l])
    );
  end

  eq_iter_cnt #(
    .ITER_W (ITER_W)
  ) i_iter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .en_i        (run_en),
    .preset_fb_i (preset_fb_i),
    .eval_req_i  (eval_req_i),
    .max_iter_i  (max_iter_i),
    .mask_i      (iter_lim_dis_i),
    .lim_hit_o   (lim_hit)
  );

  eq_timeout #(
    .CYC_PER_MS (CYC_PER_MS),
    .TIMEOUT_MS (TIMEOUT_MS)
  ) i_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (run_en),
    .tmo_o  (tmo_hit)
  );

  assign all_conv_o = &lane_conv_o;

  // priority: converged, then limit, then timeout
  always_comb begin
    rsn_d = RSN_NONE;
    if (all_conv_o)   rsn_d = RSN_CONV;
    else if (lim_hit) rsn_d = RSN_LIMIT;
    else if (tmo_hit) rsn_d = RSN_TMO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      rsn_q  <= RSN_NONE;
    end else if (clr) begin
      done_q <= 1'b0;
      rsn_q  <= RSN_NONE;
    end else if (!done_q && (rsn_d != RSN_NONE)) begin
      done_q <= 1'b1;
      rsn_q  <= rsn_d;
    end
  end

  assign done_o     = done_q;
  assign done_rsn_o = rsn_q;
endmodule

// File: rtl/eq_conv_tracker_chk.sv
`timescale 1ns/1ps
module eq_conv_tracker_chk #(
  parameter int NUM_LANES = 4,
  parameter int FB_W      = 6
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      phase_act_i,
  input logic [NUM_LANES-1:0]      fb_valid_i,
  input logic [NUM_LANES*FB_W-1:0] fb_code_i,
  input logic                      iter_lim_dis_i,
  input logic [NUM_LANES-1:0]      lane_conv_o,
  input logic                      all_conv_o,
  input logic                      done_o,
  input logic [1:0]                done_rsn_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_ln
    assert_nonzero_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_act_i && !done_o && fb_valid_i[l] && (fb_code_i[l*FB_W +: FB_W] != '0))
      |=> !lane_conv_o[l]);
  end

  assert_done_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && phase_act_i) |=> (done_o && $stable(done_rsn_o)));

  assert_frozen_lanes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && phase_act_i) |=> $stable(lane_conv_o));

  assert_phase_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_act_i |=> (!done_o && (lane_conv_o == '0) && (done_rsn_o == 2'b00)));

  assert_reason_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (done_rsn_o != 2'b00));

  assert_conv_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && (done_rsn_o == 2'b01)) |-> $past(all_conv_o));

  assert_limit_unmasked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && (done_rsn_o == 2'b10)) |-> !$past(iter_lim_dis_i));
endmodule

bind eq_conv_tracker eq_conv_tracker_chk #(
  .NUM_LANES (NUM_LANES),
  .FB_W      (FB_W)
) i_eq_conv_tracker_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .phase_act_i    (phase_act_i),
  .fb_valid_i     (fb_valid_i),
  .fb_code_i      (fb_code_i),
  .iter_lim_dis_i (iter_lim_dis_i),
  .lane_conv_o    (lane_conv_o),
  .all_conv_o     (all_conv_o),
  .done_o         (done_o),
  .done_rsn_o     (done_rsn_o)
);

// File: tb/test_eq_conv_tracker.sv
`timescale 1ns/1ps
module test_eq_conv_tracker;
  localparam int NL   = 4;
  localparam int FW   = 6;
  localparam int CW   = 3;
  localparam int IW   = 8;
  localparam int CPM  = 10;
  localparam int TMS  = 24;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              phase_act_i = 1'b0;
  logic [NL-1:0]     fb_valid_i = '0;
  logic [NL*FW-1:0]  fb_code_i = '0;
  logic              preset_fb_i = 1'b0;
  logic              eval_req_i = 1'b0;
  logic [CW-1:0]     conv_cnt_i = '0;
  logic [IW-1:0]     max_iter_i = '0;
  logic              iter_lim_dis_i = 1'b0;
  logic [NL-1:0]     lane_conv_o;
  logic              all_conv_o;
  logic              done_o;
  logic [1:0]        done_rsn_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  eq_conv_tracker #(
    .NUM_LANES (NL), .FB_W (FW), .CNT_W (CW), .ITER_W (IW),
    .CYC_PER_MS (CPM), .TIMEOUT_MS (TMS)
  ) i_eq_conv_tracker (
    .clk_i (clk_i), .rst_ni (rst_ni), .phase_act_i (phase_act_i),
    .fb_valid_i (fb_valid_i), .fb_code_i (fb_code_i),
    .preset_fb_i (preset_fb_i), .eval_req_i (eval_req_i),
    .conv_cnt_i (conv_cnt_i), .max_iter_i (max_iter_i),
    .iter_lim_dis_i (iter_lim_dis_i), .lane_conv_o (lane_conv_o),
    .all_conv_o (all_conv_o), .done_o (done_o), .done_rsn_o (done_rsn_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    fb_valid_i  = '0;
    fb_code_i   = '0;
    preset_fb_i = 1'b0;
    eval_req_i  = 1'b0;
  endtask

  task automatic fb(logic [NL-1:0] lanes, logic [FW-1:0] code, logic ev);
    fb_valid_i = lanes;
    for (int l = 0; l < NL; l++) fb_code_i[l*FW +: FW] = code;
    eval_req_i = ev;
    tick();
  endtask

  task automatic restart(logic [CW-1:0] cc, logic [IW-1:0] mx, logic msk);
    phase_act_i = 1'b0;
    tick();
    chk("R11 lanes cleared", 32'(lane_conv_o), 0);
    chk("R11 done cleared", 32'(done_o), 0);
    chk("R11 reason cleared", 32'(done_rsn_o), 0);
    conv_cnt_i = cc; max_iter_i = mx; iter_lim_dis_i = msk;
    phase_act_i = 1'b1;
  endtask

  task automatic t_lane_run();
    restart(3, 200, 0);
    fb(4'b0010, 0, 0); fb(4'b0010, 0, 0);
    chk("R1 two zeros not yet", 32'(lane_conv_o[1]), 0);
    fb(4'b0010, 6'h05, 0);
    fb(4'b0010, 0, 0); fb(4'b0010, 0, 0);
    chk("R2 run restarted by nonzero", 32'(lane_conv_o[1]), 0);
    fb(4'b0010, 0, 0);
    chk("R1 third zero converges", 32'(lane_conv_o), 32'h2);
    chk("R4 partial not all", 32'(all_conv_o), 0);
    fb(4'b0010, 6'h20, 0);
    chk("R2 nonzero drops flag", 32'(lane_conv_o[1]), 0);
    chk("R1 no done while running", 32'(done_o), 0);
  endtask

  task automatic t_zero_target();
    restart(0, 200, 0);
    fb(4'b0001, 0, 0);
    chk("R3 zero target acts as one", 32'(lane_conv_o), 32'h1);
  endtask

  task automatic t_all_conv();
    restart(2, 200, 0);
    fb(4'b1111, 0, 0);
    chk("R4 one zero not enough", 32'(all_conv_o), 0);
    fb(4'b1111, 0, 0);
    chk("R4 all lanes flagged", 32'(lane_conv_o), 32'hF);
    chk("R4 all_conv high", 32'(all_conv_o), 1);
    chk("R9 done lags all_conv", 32'(done_o), 0);
    tick();
    chk("R9 done after convergence", 32'(done_o), 1);
    chk("R9 converged reason", 32'(done_rsn_o), 32'h1);
  endtask

  task automatic t_iter_limit();
    restart(7, 3, 0);
    eval_req_i = 1; tick();
    preset_fb_i = 1; tick();
    eval_req_i = 1; tick();
    chk("R6 done lags limit", 32'(done_o), 0);
    tick();
    chk("R6 done on limit", 32'(done_o), 1);
    chk("R6 limit reason", 32'(done_rsn_o), 32'h2);
    restart(7, 4, 0);
    preset_fb_i = 1; eval_req_i = 1; tick();
    chk("R5 two counted, below four", 32'(done_o), 0);
    preset_fb_i = 1; eval_req_i = 1; tick();
    chk("R5 four reached, done pending", 32'(done_o), 0);
    tick();
    chk("R5 double events reach limit", 32'(done_o), 1);
    chk("R5 reason limit", 32'(done_rsn_o), 32'h2);
  endtask

  task automatic t_mask();
    restart(1, 2, 1);
    for (int i = 0; i < 5; i++) begin eval_req_i = 1; tick(); end
    tick();
    chk("R7 masked limit ignored", 32'(done_o), 0);
    fb(4'b1111, 0, 0);
    tick();
    chk("R7 masked, converged ends", 32'(done_o), 1);
    chk("R7 reason converged", 32'(done_rsn_o), 32'h1);
  endtask

  task automatic t_timeout();
    restart(7, 0, 1);
    for (int i = 0; i < CPM*TMS; i++) tick();
    chk("R8 not before timeout", 32'(done_o), 0);
    tick();
    chk("R8 done on timeout", 32'(done_o), 1);
    chk("R8 timeout reason", 32'(done_rsn_o), 32'h3);
  endtask

  task automatic t_same_cycle();
    restart(1, 2, 0);
    eval_req_i = 1; tick();
    fb(4'b1111, 0, 1);
    chk("R9 conv and limit together", 32'(all_conv_o), 1);
    tick();
    chk("R9 done set", 32'(done_o), 1);
    chk("R9 converged beats limit", 32'(done_rsn_o), 32'h1);
  endtask

  task automatic t_freeze();
    restart(1, 1, 0);
    fb(4'b0001, 0, 1);
    tick();
    chk("R10 limit reached", 32'(done_rsn_o), 32'h2);
    fb(4'b0011, 0, 0);
    fb(4'b0001, 6'h11, 1);
    chk("R10 lane flags frozen", 32'(lane_conv_o), 32'h1);
    chk("R10 done holds", 32'(done_o), 1);
    chk("R10 reason holds", 32'(done_rsn_o), 32'h2);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R11 reset done low", 32'(done_o), 0);
    chk("R11 reset lanes low", 32'(lane_conv_o), 0);
    rst_ni = 1'b1;
    tick();
    t_lane_run();
    t_zero_target();
    t_all_conv();
    t_iter_limit();
    t_mask();
    t_timeout();
    t_same_cycle();
    t_freeze();
    restart(1, 200, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule